// File: doc/BRIEF.md
# Write-Back Data Cache with Uncached Bypass

This block sits between a 32-bit load/store unit and a 32-bit pipelined memory bus. It keeps a direct-mapped array of lines. Loads and stores that hit finish in the cycle they are presented. A miss stalls the processor while the block refills the line. If the victim line holds modified data, the block first writes that line back to memory. Stores that hit change only the cache and mark the line modified. A store that misses first brings the line in and then merges its bytes into it.

Some accesses must reach the bus every time, for example to peripherals. The processor marks these either by setting address bit 31 or by raising the per-access I/O flag. Such an access becomes one uncached bus transfer at the address with bit 31 cleared. It never reads or changes a cache line.

The processor holds its request, which is read or write, address, byte enables, data and I/O flag, until it sees `cpu_stall` low at a rising clock edge. The bus side follows a wait-request handshake: a read or write is accepted on an edge where `mem_wait` is low. Read data comes back later and in order, marked by `mem_rvalid`.

Top module: `dcache_wb`

## Requirements
- R1: After reset every line is invalid and no bus request is driven. With no processor request, `cpu_stall` is low. The first cached access always misses.
- R2: A cached read that hits completes with `cpu_stall` low in the cycle it is presented and causes no bus activity.
- R3: A miss to a clean line issues exactly LINE_BYTES/4 bus reads. Their addresses rise by 4 from the line base. While `mem_wait` is low they are issued on consecutive cycles without waiting for returned data.
- R4: A cached store that hits writes only the bytes whose enable bit is set and causes no bus transfer. Byte enable bit k selects data bits 8k+7..8k, so byte 0 is the least significant.
- R5: A cached store that misses first fills the line from memory and then merges its enabled bytes. It writes nothing to the bus when the victim is clean.
- R6: A miss whose victim line is modified first writes all LINE_BYTES/4 words of the victim to its old address. Only after those writes does it issue the reads for the new line.
- R7: An access with address bit 31 set produces exactly one bus transfer at the same address with bit 31 cleared. A bypassed read returns the bus data.
- R8: An access with `cpu_io` high produces exactly one bus transfer even when the address is cached. A bypassed read returns the bus data.
- R9: A bypassed store drives exactly the processor's byte enables on the bus. It leaves the contents of any cached line at that address unchanged.
- R10: While `mem_wait` is high, a pending bus request keeps its address, data, byte enables and direction unchanged.
- R11: Address bits 4..0 select the byte in a line, the next log2(NUM_LINES) bits select the line, and the rest form the tag. With the default of 32 lines, two addresses 1 KB apart map to the same line and displace each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_rd | input | 1 | Load request |
| cpu_wr | input | 1 | Store request |
| cpu_be | input | 4 | Byte enables, bit k for byte k |
| cpu_wdata | input | 32 | Store data |
| cpu_io | input | 1 | Force an uncached bus transfer |
| cpu_rdata | output | 32 | Load data, valid when the request completes |
| cpu_stall | output | 1 | Request not completed this cycle |
| mem_addr | output | 32 | Bus byte address |
| mem_rd | output | 1 | Bus read request |
| mem_wr | output | 1 | Bus write request |
| mem_be | output | 4 | Bus byte enables |
| mem_wdata | output | 32 | Bus write data |
| mem_wait | input | 1 | Bus not ready; hold the request |
| mem_rvalid | input | 1 | Returned read data is valid |
| mem_rdata | input | 32 | Returned read data |

## Verification
Directed sequences drive each cache path on its own: a cold read miss, a repeated read that must hit, and a partial store hit. They continue with a conflicting address that forces a dirty eviction, a store miss into an empty line, and bit-31 and I/O-flag transfers. Counting bus reads and writes per access separates a hit from a clean fill and a dirty eviction. An uncached store over a cached word, followed by a cached read of that word, shows whether the bypass touched the line. A long random mix of cached and uncached loads and stores with random byte enables and bus wait states then runs against a byte-level model of memory as the processor should see it. This exposes lost dirty data, wrong merges and handshake slips.

// File: rtl/dcache_wb.sv
`timescale 1ns/1ps
module dcache_wb #(
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [3:0]  cpu_be,
  input  logic [31:0] cpu_wdata,
  input  logic        cpu_io,
  output logic [31:0] cpu_rdata,
  output logic        cpu_stall,
  output logic [31:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic        mem_wait,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  localparam int WORDS   = LINE_BYTES / 4;
  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int IDX_W   = $clog2(NUM_LINES);
  localparam int TAG_W   = 32 - OFF_W - IDX_W;
  localparam int ENT_W   = IDX_W + OFF_W - 2;
  localparam int CNT_W   = $clog2(WORDS) + 1;
  localparam int ENTRIES = NUM_LINES * WORDS;

  typedef enum logic [2:0] {S_IDLE, S_EVICT, S_FILL, S_URD, S_UWAIT, S_UWR, S_UDONE} st_t;

  logic [31:0]          data_q [ENTRIES];
  logic [TAG_W-1:0]     tag_q  [NUM_LINES];
  logic [NUM_LINES-1:0] valid_q, dirty_q;
  logic [CNT_W-1:0]     issue_cnt, recv_cnt;
  logic [31:0]          unc_data;
  st_t                  st;

  wire              req    = cpu_rd | cpu_wr;
  wire              bypass = cpu_addr[31] | cpu_io;
  wire [IDX_W-1:0]  idx    = cpu_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  tag    = cpu_addr[31 -: TAG_W];
  wire [ENT_W-1:0]  ent    = cpu_addr[2 +: ENT_W];
  wire              hit    = valid_q[idx] && (tag_q[idx] == tag);
  wire              hit_go = (st == S_IDLE) && req && !bypass && hit;

  wire [ENT_W-1:0]  line_ent   = ENT_W'(idx) << (OFF_W - 2);
  wire [ENT_W-1:0]  evict_ent  = line_ent + ENT_W'(issue_cnt);
  wire [ENT_W-1:0]  fill_ent   = line_ent + ENT_W'(recv_cnt);
  wire [31:0]       new_base   = {cpu_addr[31:OFF_W], {OFF_W{1'b0}}};
  wire [31:0]       old_base   = {tag_q[idx], idx, {OFF_W{1'b0}}};
  wire [31:0]       word_off   = 32'(issue_cnt) << 2;
  wire              last_issue = issue_cnt == CNT_W'(WORDS - 1);
  wire              last_recv  = recv_cnt == CNT_W'(WORDS - 1);

  assign cpu_stall = req && !hit_go && (st != S_UDONE);
  assign cpu_rdata = (st == S_UDONE) ? unc_data : data_q[ent];

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = 32'd0;
    mem_be    = 4'hF;
    mem_wdata = 32'd0;
    case (st)
      S_EVICT: begin
        mem_wr    = 1'b1;
        mem_addr  = old_base + word_off;
        mem_wdata = data_q[evict_ent];
      end
      S_FILL: begin
        mem_rd   = issue_cnt < CNT_W'(WORDS);
        mem_addr = new_base + word_off;
      end
      S_URD: begin
        mem_rd   = 1'b1;
        mem_addr = {1'b0, cpu_addr[30:0]};
        mem_be   = cpu_be;
      end
      S_UWR: begin
        mem_wr    = 1'b1;
        mem_addr  = {1'b0, cpu_addr[30:0]};
        mem_be    = cpu_be;
        mem_wdata = cpu_wdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      valid_q   <= '0;
      dirty_q   <= '0;
      issue_cnt <= '0;
      recv_cnt  <= '0;
      unc_data  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          if (bypass) st <= cpu_rd ? S_URD : S_UWR;
          else if (!hit) begin
            issue_cnt <= '0;
            recv_cnt  <= '0;
            st <= (valid_q[idx] && dirty_q[idx]) ? S_EVICT : S_FILL;
          end else if (cpu_wr) dirty_q[idx] <= 1'b1;
        end
        S_EVICT: if (!mem_wait) begin
          if (last_issue) begin
            issue_cnt <= '0;
            st <= S_FILL;
          end else issue_cnt <= issue_cnt + 1'b1;
        end
        S_FILL: begin
          if (mem_rd && !mem_wait) issue_cnt <= issue_cnt + 1'b1;
          if (mem_rvalid) begin
            recv_cnt <= recv_cnt + 1'b1;
            if (last_recv) begin
              valid_q[idx] <= 1'b1;
              dirty_q[idx] <= 1'b0;
              tag_q[idx]   <= tag;
              st <= S_IDLE;
            end
          end
        end
        S_URD:   if (!mem_wait) st <= S_UWAIT;
        S_UWAIT: if (mem_rvalid) begin
          unc_data <= mem_rdata;
          st <= S_UDONE;
        end
        S_UWR:   if (!mem_wait) st <= S_UDONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FILL && mem_rvalid) data_q[fill_ent] <= mem_rdata;
    else if (hit_go && cpu_wr) begin
      for (int b = 0; b < 4; b++)
        if (cpu_be[b]) data_q[ent][8*b +: 8] <= cpu_wdata[8*b +: 8];
    end
  end

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) && mem_wait |=> $stable(mem_addr) && $stable(mem_rd)
      && $stable(mem_wr) && $stable(mem_wdata) && $stable(mem_be));
  // R2
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_go |-> !mem_rd && !mem_wr);
  // R7
  bus_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> !mem_addr[31]);
  // R3
  fill_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_FILL |-> recv_cnt <= issue_cnt && issue_cnt <= CNT_W'(WORDS));
  // R6
  evict_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_EVICT |-> !mem_rd);
  // R9
  bypass_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_UWR |=> $stable(valid_q) && $stable(dirty_q));
endmodule

// File: tb/tb_dcache_wb.sv
`timescale 1ns/1ps
module tb_dcache_wb;
  localparam int WORDS = 8;

  logic        clk = 0, rst_n = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0, cpu_rdata;
  logic        cpu_rd = 0, cpu_wr = 0, cpu_io = 0, cpu_stall;
  logic [3:0]  cpu_be = 0;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rd, mem_wr;
  logic [3:0]  mem_be;
  logic        mem_wait = 0, mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;

  dcache_wb dut (.*);

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [31:0] ext_mem  [4096];
  logic [31:0] cpu_view [4096];
  logic [11:0] rq [$];
  bit          wait_en = 0;
  int          rd_n = 0, wr_n = 0, hold_err = 0, range_err = 0;
  logic [31:0] rd_log [1024];
  int          rd_cyc [1024];
  logic [31:0] wr_log [1024];
  logic [3:0]  wr_be  [1024];
  int          wr_cyc [1024];
  bit          pend = 0;
  logic [31:0] p_addr, p_data;
  logic        p_rd, p_wr;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  always @(negedge clk) begin
    mem_wait = wait_en && ($urandom % 100 < 30);
    if (rq.size() > 0 && ($urandom % 100 < 70)) begin
      mem_rvalid = 1;
      mem_rdata  = ext_mem[rq.pop_front()];
    end else mem_rvalid = 0;
    #1;
    if (pend && (mem_addr != p_addr || mem_rd != p_rd || mem_wr != p_wr || (p_wr && mem_wdata != p_data)))
      hold_err++;
    pend = (mem_rd || mem_wr) && mem_wait;
    p_addr = mem_addr; p_rd = mem_rd; p_wr = mem_wr; p_data = mem_wdata;
    if ((mem_rd || mem_wr) && mem_addr[31:14] != 0) range_err++;
    if (mem_rd && !mem_wait) begin
      rq.push_back(mem_addr[13:2]);
      rd_log[rd_n % 1024] = mem_addr; rd_cyc[rd_n % 1024] = cyc; rd_n++;
    end
    if (mem_wr && !mem_wait) begin
      ext_mem[mem_addr[13:2]] = merge(ext_mem[mem_addr[13:2]], mem_wdata, mem_be);
      wr_log[wr_n % 1024] = mem_addr; wr_be[wr_n % 1024] = mem_be;
      wr_cyc[wr_n % 1024] = cyc; wr_n++;
    end
  end

  task automatic chk(input bit ok, input string rq_tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", rq_tag, what, act, exp);
    end
  endtask

  task automatic acc(input logic [31:0] a, input bit w, input logic [3:0] be,
                     input logic [31:0] wd, input bit io,
                     output logic [31:0] rdv, output int stalls);
    @(negedge clk);
    cpu_addr = a; cpu_rd = !w; cpu_wr = w; cpu_be = be; cpu_wdata = wd; cpu_io = io;
    stalls = 0;
    while (1) begin
      #1;
      if (!cpu_stall) begin rdv = cpu_rdata; break; end
      stalls++;
      @(negedge clk);
    end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    cpu_rd = 0; cpu_wr = 0; cpu_io = 0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    report();
  end

  initial begin
    logic [31:0] r, old, mrg;
    int st, r0, w0;
    bit ok;
    for (int i = 0; i < 4096; i++) begin
      ext_mem[i]  = (i * 32'h9E3779B9) ^ 32'h5A5A0000;
      cpu_view[i] = ext_mem[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1 reset state
    chk(!cpu_stall && !mem_rd && !mem_wr, "R1", "idle after reset", {29'd0, cpu_stall, mem_rd, mem_wr}, 0);

    // R1 R3 cold miss, pipelined fill
    r0 = rd_n; w0 = wr_n;
    acc(32'h40, 0, 4'hF, 0, 0, r, st);
    chk(rd_n - r0 == WORDS, "R1", "cold miss reads", rd_n - r0, WORDS);
    chk(wr_n == w0, "R3", "clean fill writes", wr_n - w0, 0);
    ok = 1;
    for (int k = 0; k < WORDS; k++) if (rd_log[(r0 + k) % 1024] != 32'h40 + 4 * k) ok = 0;
    chk(ok, "R3", "fill addresses", rd_log[r0 % 1024], 32'h40);
    ok = 1;
    for (int k = 1; k < WORDS; k++) if (rd_cyc[(r0 + k) % 1024] != rd_cyc[(r0 + k - 1) % 1024] + 1) ok = 0;
    chk(ok, "R3", "back-to-back issue", rd_cyc[(r0 + 1) % 1024] - rd_cyc[r0 % 1024], 1);
    chk(r == cpu_view[16], "R3", "miss data", r, cpu_view[16]);

    // R2 hit
    r0 = rd_n;
    acc(32'h40, 0, 4'hF, 0, 0, r, st);
    chk(st == 0 && rd_n == r0, "R2", "hit stall/bus", st, 0);
    chk(r == cpu_view[16], "R2", "hit data", r, cpu_view[16]);

    // R4 partial store hit
    old = cpu_view[17]; mrg = {old[31:16], 8'hCC, old[7:0]};
    w0 = wr_n;
    acc(32'h44, 1, 4'b0010, 32'hAABBCCDD, 0, r, st);
    cpu_view[17] = mrg;
    chk(st == 0 && wr_n == w0, "R4", "store hit no bus", wr_n - w0, 0);
    acc(32'h44, 0, 4'hF, 0, 0, r, st);
    chk(r == mrg, "R4", "byte merge", r, mrg);

    // R6 R11 dirty eviction via conflicting tag
    r0 = rd_n; w0 = wr_n;
    acc(32'h440, 0, 4'hF, 0, 0, r, st);
    chk(wr_n - w0 == WORDS && wr_log[w0 % 1024] == 32'h40, "R6", "writeback count/addr", wr_log[w0 % 1024], 32'h40);
    chk(ext_mem[17] == mrg, "R6", "dirty word written", ext_mem[17], mrg);
    chk(wr_cyc[(w0 + WORDS - 1) % 1024] < rd_cyc[r0 % 1024], "R6", "writes precede reads",
        wr_cyc[(w0 + WORDS - 1) % 1024], rd_cyc[r0 % 1024]);
    chk(r == cpu_view[32'h440 >> 2], "R11", "conflict line data", r, cpu_view[32'h440 >> 2]);
    r0 = rd_n; w0 = wr_n;
    acc(32'h44, 0, 4'hF, 0, 0, r, st);
    chk(rd_n - r0 == WORDS && wr_n == w0, "R11", "displaced line refetched", rd_n - r0, WORDS);
    chk(r == mrg, "R11", "refetched data", r, mrg);

    // R5 store miss allocate
    r0 = rd_n; w0 = wr_n;
    acc(32'h884, 1, 4'hF, 32'h12345678, 0, r, st);
    cpu_view[32'h884 >> 2] = 32'h12345678;
    chk(rd_n - r0 == WORDS && wr_n == w0, "R5", "allocate fill", rd_n - r0, WORDS);
    acc(32'h880, 0, 4'hF, 0, 0, r, st);
    chk(st == 0 && r == cpu_view[32'h880 >> 2], "R5", "neighbour word", r, cpu_view[32'h880 >> 2]);
    acc(32'h884, 0, 4'hF, 0, 0, r, st);
    chk(r == 32'h12345678, "R5", "merged store", r, 32'h12345678);

    // R7 bit-31 bypass read
    r0 = rd_n;
    acc(32'h80002010, 0, 4'hF, 0, 0, r, st);
    chk(rd_n - r0 == 1 && rd_log[r0 % 1024] == 32'h2010, "R7", "single read bit31 cleared", rd_log[r0 % 1024], 32'h2010);
    chk(r == ext_mem[32'h2010 >> 2], "R7", "bypass data", r, ext_mem[32'h2010 >> 2]);

    // R8 R9 io store then io read
    w0 = wr_n;
    mrg = merge(cpu_view[32'h2020 >> 2], 32'h11223344, 4'b0110);
    acc(32'h2020, 1, 4'b0110, 32'h11223344, 1, r, st);
    cpu_view[32'h2020 >> 2] = mrg;
    chk(wr_n - w0 == 1 && wr_log[w0 % 1024] == 32'h2020, "R8", "io single write", wr_log[w0 % 1024], 32'h2020);
    chk(wr_be[w0 % 1024] == 4'b0110, "R9", "bypass byte enables", {28'd0, wr_be[w0 % 1024]}, 4'b0110);
    r0 = rd_n;
    acc(32'h2020, 0, 4'hF, 0, 1, r, st);
    chk(rd_n - r0 == 1 && r == mrg, "R8", "io read data", r, mrg);

    // R8 R9 bypass store over a cached word leaves the line alone
    acc(32'h440, 0, 4'hF, 0, 0, r, st);
    old = cpu_view[32'h444 >> 2];
    w0 = wr_n; r0 = rd_n;
    acc(32'h444, 1, 4'b0001, 32'h000000EE, 1, r, st);
    chk(wr_n - w0 == 1 && wr_be[w0 % 1024] == 4'b0001, "R8", "io write on cached addr", wr_n - w0, 1);
    acc(32'h444, 0, 4'hF, 0, 0, r, st);
    chk(st == 0 && r == old, "R9", "cached line unchanged", r, old);
    acc(32'h80000444, 1, 4'b0001, old, 0, r, st);

    // random mix
    wait_en = 1;
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, wd;
      logic [3:0] be;
      bit w, io;
      w  = $urandom % 2;
      io = 0;
      wd = $urandom;
      be = 4'($urandom % 15 + 1);
      if ($urandom % 4 == 0) begin
        a = 32'h2000 + (($urandom % 2048) << 2);
        if ($urandom % 2) a[31] = 1'b1; else io = 1;
      end else a = ($urandom % 2048) << 2;
      acc(a, w, be, wd, io, r, st);
      if (w) cpu_view[a[13:2]] = merge(cpu_view[a[13:2]], wd, be);
      else chk(r == cpu_view[a[13:2]], (a[31] || io) ? "R7" : "R4", "random read", r, cpu_view[a[13:2]]);
    end
    idle();
    chk(hold_err == 0, "R10", "request held under wait", hold_err, 0);
    chk(range_err == 0, "R7", "bus address range", range_err, 0);
    report();
  end
endmodule